// File: doc/BRIEF.md
# Dual-Bank Calibration Store with Timed Reload

This block holds the calibration words of a display reference driver: eight gamma levels, one common-electrode level and the upper and lower clamp values for that common level. Each word is `DW` bits wide and has its own copy in each of two banks. The storage is a register array that stands in for one-time-programmable cells. Every location can be programmed a limited number of times. A per-location counter enforces that limit, and the same counter tells an unwritten location apart from a written one.

The working registers live outside this block. The controller refills them by streaming load strobes with an index and data. A refill of every location runs at power-up, whenever the bank-select pin changes level, and on a general acquire command. A single-channel acquire refills only the addressed location. Each kind of acquire waits for its own programmable number of cycles before the loads appear, and `busy` covers the whole operation.

When an acquire finishes, a read-only count register is updated. After a single-channel acquire it reports how often that location has been programmed in the bank used. After a full acquire it reports the largest such count among the nine output channels.

Top module: `nvacq_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `ld_valid`, `busy`, `prog_err` and `wcount` are 0. The first rising edge with `rst` low starts a full reload from the bank named by `bank_sel` (1 selects bank 1, 0 selects bank 0).
- R2: A full reload emits `NCH` loads with indices 0 to `NCH`-1, in ascending order, one per cycle. The first load is visible `GEN_LAT`+1 cycles after the edge that accepted the start.
- R3: A location never programmed in the bank used loads a default value: 0x200 for indices 0–8 (gamma channels 0–7 and the common level at index 8), 0x3FF for index 9 (upper clamp) and 0x000 for index 10 (lower clamp).
- R4: A change of `bank_sel` is seen at the next edge and causes one full reload from the new bank. The reload starts at the following edge, or once the block is idle if an operation is running.
- R5: `sgl_acq` with `acq_idx` below `NCH` produces exactly one load of that index, visible `SGL_LAT`+1 cycles after acceptance. An index of `NCH` or above is ignored, and `busy` stays low.
- R6: `busy` rises in the cycle after a start is accepted and stays high through the cycle of the last load. It falls in the next cycle. Commands that arrive while `busy` is high are dropped. When `gen_acq` and `sgl_acq` arrive together, the full reload wins.
- R7: `wcount` changes only in the cycle in which `busy` falls. After a single acquire it holds the program count of that location. After a full reload it holds the largest count over indices 0–8; the clamp locations are excluded.
- R8: `prog_req` writes `prog_data` to index `prog_idx` of the bank named by `bank_sel` in that cycle and increments that location's count. A `prog_idx` of `NCH` or above is ignored.
- R9: A program request to a location whose count is already `MAX_PROG` leaves its data and count unchanged and sets `prog_err`. `prog_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank select level |
| gen_acq | input | 1 | Full acquire command strobe |
| sgl_acq | input | 1 | Single-channel acquire command strobe |
| acq_idx | input | IW | Location index for single acquire |
| prog_req | input | 1 | Program request strobe |
| prog_idx | input | IW | Location index to program |
| prog_data | input | DW | Value to program |
| ld_valid | output | 1 | Working-register load strobe |
| ld_idx | output | IW | Index of the location being loaded |
| ld_data | output | DW | Value to load |
| busy | output | 1 | Acquire in progress |
| wcount | output | CW | Program-count report |
| prog_err | output | 1 | Sticky program-limit violation |

## Verification
The bench keeps `NCH`=11, `DW`=10 and `MAX_PROG`=16, so that the sixteen-program limit is actually exhausted on a real location. It shortens `GEN_LAT` to 20 and `SGL_LAT` to 4, which puts many full and single acquires, bank flips in the middle of a reload, and dropped commands into a short run. With those latencies, load timing, `busy` edges and the count report are compared against a behavioural model on every cycle.

// File: rtl/nvacq_pkg.sv
package nvacq_pkg;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LOAD, S_DONE} seq_state_t;
endpackage

// File: rtl/nvacq_store.sv
module nvacq_store #(
  parameter int NCH      = 11,
  parameter int DW       = 10,
  parameter int MAX_PROG = 16,
  localparam int IW      = $clog2(NCH),
  localparam int CW      = $clog2(MAX_PROG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          wr_bank,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_bank,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [IW-1:0] rd_idx_q,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] sel_cnt,
  output logic [CW-1:0] max_cnt,
  output logic          wr_reject
);
  localparam int            DEPTH = 2 ** (IW + 1);
  localparam int            NOUT  = NCH - 2;
  localparam logic [IW-1:0] LAST  = IW'(NCH - 1);
  localparam logic [IW-1:0] HI_IX = IW'(NCH - 2);
  localparam logic [CW-1:0] CMAX  = CW'(MAX_PROG);
  localparam logic [DW-1:0] MID   = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] FULL  = '1;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q [2][NCH];
  logic [DW-1:0] mem_q, dflt_q;
  logic          blank_q;
  logic          wr_in, wr_ok;

  assign wr_in     = wr_req && (wr_idx <= LAST);
  assign wr_reject = wr_in && (cnt_q[wr_bank][wr_idx] == CMAX);
  assign wr_ok     = wr_in && !wr_reject;
  assign sel_cnt   = cnt_q[rd_bank][rd_idx];

  always_comb begin
    max_cnt = '0;
    for (int c = 0; c < NOUT; c++)
      if (cnt_q[rd_bank][c] > max_cnt) max_cnt = cnt_q[rd_bank][c];
  end

  // storage array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[{wr_bank, wr_idx}] <= wr_data;
    if (rd_en) mem_q <= mem[{rd_bank, rd_idx}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < NCH; c++) cnt_q[b][c] <= '0;
      rd_valid <= 1'b0;
      rd_idx_q <= '0;
      blank_q  <= 1'b0;
      dflt_q   <= '0;
    end else begin
      if (wr_ok) cnt_q[wr_bank][wr_idx] <= cnt_q[wr_bank][wr_idx] + CW'(1);
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_idx_q <= rd_idx;
        blank_q  <= (sel_cnt == '0);
        dflt_q   <= (rd_idx < HI_IX) ? MID : (rd_idx == HI_IX) ? FULL : '0;
      end
    end
  end

  assign rd_data = blank_q ? dflt_q : mem_q;

  p_read_follows_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: rtl/nvacq_seq.sv
module nvacq_seq
  import nvacq_pkg::*;
#(
  parameter int NCH     = 11,
  parameter int GEN_LAT = 93750,
  parameter int SGL_LAT = 4500,
  localparam int IW     = $clog2(NCH),
  localparam int LW     = $clog2((GEN_LAT > SGL_LAT ? GEN_LAT : SGL_LAT) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_sel,
  input  logic          gen_acq,
  input  logic          sgl_acq,
  input  logic [IW-1:0] acq_idx,
  output logic          busy,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [IW-1:0] rd_idx,
  output logic          done,
  output logic          done_gen
);
  localparam logic [IW-1:0] LAST = IW'(NCH - 1);

  seq_state_t    state;
  logic [LW-1:0] wait_q;
  logic          bank_prev, pend, gen_q;
  logic          start_gen, start_sgl;

  assign start_gen = (state == S_IDLE) && (pend || gen_acq);
  assign start_sgl = (state == S_IDLE) && !start_gen && sgl_acq && (acq_idx <= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pend      <= 1'b1;
      bank_prev <= bank_sel;
      busy      <= 1'b0;
      gen_q     <= 1'b0;
      rd_bank   <= 1'b0;
      rd_idx    <= '0;
      wait_q    <= '0;
    end else begin
      bank_prev <= bank_sel;
      pend      <= (pend && !start_gen) || (bank_sel != bank_prev);
      case (state)
        S_IDLE: if (start_gen || start_sgl) begin
          state   <= S_WAIT;
          busy    <= 1'b1;
          gen_q   <= start_gen;
          rd_bank <= bank_sel;
          rd_idx  <= start_gen ? '0 : acq_idx;
          wait_q  <= start_gen ? LW'(GEN_LAT - 1) : LW'(SGL_LAT - 1);
        end
        S_WAIT: if (wait_q == '0) state <= S_LOAD;
                else wait_q <= wait_q - LW'(1);
        S_LOAD: if (!gen_q || rd_idx == LAST) state <= S_DONE;
                else rd_idx <= rd_idx + IW'(1);
        default: begin
          state <= S_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  assign rd_en    = (state == S_LOAD);
  assign done     = (state == S_DONE);
  assign done_gen = gen_q;

  p_load_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
  p_bank_change_pends_r4: assert property (@(posedge clk) disable iff (rst)
    (bank_sel != bank_prev) |=> pend);
endmodule

// File: rtl/nvacq_ctrl.sv
module nvacq_ctrl #(
  parameter int NCH      = 11,
  parameter int DW       = 10,
  parameter int MAX_PROG = 16,
  parameter int GEN_LAT  = 93750,
  parameter int SGL_LAT  = 4500,
  localparam int IW      = $clog2(NCH),
  localparam int CW      = $clog2(MAX_PROG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_sel,
  input  logic          gen_acq,
  input  logic          sgl_acq,
  input  logic [IW-1:0] acq_idx,
  input  logic          prog_req,
  input  logic [IW-1:0] prog_idx,
  input  logic [DW-1:0] prog_data,
  output logic          ld_valid,
  output logic [IW-1:0] ld_idx,
  output logic [DW-1:0] ld_data,
  output logic          busy,
  output logic [CW-1:0] wcount,
  output logic          prog_err
);
  logic          rd_en, rd_bank, done, done_gen, wr_reject;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] sel_cnt, max_cnt;

  nvacq_seq #(.NCH(NCH), .GEN_LAT(GEN_LAT), .SGL_LAT(SGL_LAT)) u_seq (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .gen_acq(gen_acq),
    .sgl_acq(sgl_acq), .acq_idx(acq_idx), .busy(busy), .rd_en(rd_en),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .done(done), .done_gen(done_gen));

  nvacq_store #(.NCH(NCH), .DW(DW), .MAX_PROG(MAX_PROG)) u_store (
    .clk(clk), .rst(rst), .wr_req(prog_req), .wr_bank(bank_sel),
    .wr_idx(prog_idx), .wr_data(prog_data), .rd_en(rd_en), .rd_bank(rd_bank),
    .rd_idx(rd_idx), .rd_valid(ld_valid), .rd_idx_q(ld_idx), .rd_data(ld_data),
    .sel_cnt(sel_cnt), .max_cnt(max_cnt), .wr_reject(wr_reject));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcount   <= '0;
      prog_err <= 1'b0;
    end else begin
      if (done) wcount <= done_gen ? max_cnt : sel_cnt;
      if (wr_reject) prog_err <= 1'b1;
    end
  end

  p_ld_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> (ld_idx <= IW'(NCH - 1)));
  p_wcount_on_finish_r7: assert property (@(posedge clk) disable iff (rst)
    (wcount != $past(wcount)) |-> ($past(busy) && !busy));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    prog_err |=> prog_err);
endmodule

// File: tb/tb_nvacq_ctrl.sv
module tb_nvacq_ctrl;
  localparam int NCH = 11, DW = 10, MAXP = 16, GL = 20, SL = 4;
  localparam int IW = $clog2(NCH), CW = $clog2(MAXP + 1);

  logic clk = 0, rst = 1, bank_sel = 0, gen_acq = 0, sgl_acq = 0, prog_req = 0;
  logic [IW-1:0] acq_idx = '0, prog_idx = '0;
  logic [DW-1:0] prog_data = '0;
  logic ld_valid, busy, prog_err;
  logic [IW-1:0] ld_idx;
  logic [DW-1:0] ld_data;
  logic [CW-1:0] wcount;

  nvacq_ctrl #(.NCH(NCH), .DW(DW), .MAX_PROG(MAXP), .GEN_LAT(GL), .SGL_LAT(SL)) dut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .gen_acq(gen_acq), .sgl_acq(sgl_acq),
    .acq_idx(acq_idx), .prog_req(prog_req), .prog_idx(prog_idx), .prog_data(prog_data),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data), .busy(busy),
    .wcount(wcount), .prog_err(prog_err));

  always #4 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  int mmem [2][NCH];
  int mcnt [2][NCH];
  int last_ld [NCH];
  bit m_busy, m_gen, m_bank, pend, prev, e_valid, e_busy, e_err;
  int m_t, m_base, m_lat, m_n, e_idx, e_data, e_wc;

  function automatic int dflt(int i);
    return (i < 9) ? 'h200 : (i == 9) ? 'h3FF : 0;
  endfunction
  function automatic int value(bit b, int i);
    return (mcnt[b][i] == 0) ? dflt(i) : mmem[b][i];
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; pend = 1; prev = bank_sel; e_valid = 0; e_busy = 0;
      e_err = 0; e_wc = 0;
      for (int b = 0; b < 2; b++) for (int i = 0; i < NCH; i++) mcnt[b][i] = 0;
    end else begin
      bit chg, sg;
      chg = (bank_sel != prev); sg = 0; e_valid = 0;
      if (m_busy) begin
        m_t++;
        if (m_t >= m_lat + 1 && m_t <= m_lat + m_n) begin
          e_valid = 1; e_idx = m_base + m_t - m_lat - 1; e_data = value(m_bank, e_idx);
        end
        if (m_t == m_lat + m_n + 1) begin
          m_busy = 0;
          if (m_gen) begin
            e_wc = 0;
            for (int i = 0; i < 9; i++) if (mcnt[m_bank][i] > e_wc) e_wc = mcnt[m_bank][i];
          end else e_wc = mcnt[m_bank][m_base];
        end
      end else if (pend || gen_acq) begin
        sg = 1; m_busy = 1; m_t = 0; m_gen = 1; m_bank = bank_sel; m_base = 0;
        m_lat = GL; m_n = NCH;
      end else if (sgl_acq && acq_idx < NCH) begin
        m_busy = 1; m_t = 0; m_gen = 0; m_bank = bank_sel; m_base = acq_idx;
        m_lat = SL; m_n = 1;
      end
      pend = (pend && !sg) || chg;
      prev = bank_sel;
      if (prog_req && prog_idx < NCH) begin
        if (mcnt[bank_sel][prog_idx] == MAXP) e_err = 1;
        else begin
          mmem[bank_sel][prog_idx] = prog_data;
          mcnt[bank_sel][prog_idx]++;
        end
      end
      e_busy = m_busy;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    check("R2 ld_valid", ld_valid, e_valid);
    if (e_valid) begin
      check("R2 ld_idx", ld_idx, e_idx);
      check("R3 ld_data", ld_data, e_data);
    end
    check("R6 busy", busy, e_busy);
    check("R7 wcount", wcount, e_wc);
    check("R9 prog_err", prog_err, e_err);
    if (ld_valid) last_ld[ld_idx] = ld_data;
  end

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic prog(int b, int i, int d);
    @(negedge clk); bank_sel = b[0]; prog_req = 1; prog_idx = i[IW-1:0]; prog_data = d[DW-1:0];
    @(negedge clk); prog_req = 0;
  endtask
  task automatic cmd(bit g, bit s, int i);
    @(negedge clk); gen_acq = g; sgl_acq = s; acq_idx = i[IW-1:0];
    @(negedge clk); gen_acq = 0; sgl_acq = 0;
  endtask
  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset wcount", wcount, 0);
    check("R1 reset err", prog_err, 0);
    rst = 0;
    wait_idle();
    check("R3 gamma default", last_ld[0], 'h200);
    check("R3 upper clamp default", last_ld[9], 'h3FF);
    check("R3 lower clamp default", last_ld[10], 0);
    prog(0, 0, 'h011);
    for (int k = 0; k < 3; k++) prog(0, 3, 'h2A9 + k);
    prog(0, 9, 'h300);
    prog(0, 12, 'h0FF);
    cmd(1, 0, 0); wait_idle();
    check("R2 full reload data", last_ld[3], 'h2AB);
    check("R7 max count", wcount, 3);
    for (int k = 0; k < 5; k++) prog(0, 10, 'h040 + k);
    cmd(1, 0, 0); wait_idle();
    check("R7 clamps excluded", wcount, 3);
    cmd(0, 1, 10); wait_idle();
    check("R5 single data", last_ld[10], 'h044);
    check("R7 single count", wcount, 5);
    cmd(0, 1, 11);
    check("R5 bad index ignored", busy, 0);
    cmd(1, 1, 2); wait_idle();
    check("R6 general wins", wcount, 3);
    cmd(1, 0, 0); cmd(0, 1, 4); wait_idle();
    check("R6 drop while busy", wcount, 3);
    for (int k = 0; k < 5; k++) prog(1, 0, 'h151 + k);
    wait_idle();
    check("R4 bank1 reload", last_ld[0], 'h155);
    check("R4 bank1 count", wcount, 5);
    cmd(1, 0, 0); @(negedge clk); bank_sel = 0; wait_idle(); wait_idle();
    check("R4 deferred reload", last_ld[0], 'h011);
    @(negedge clk); bank_sel = 1; wait_idle();
    for (int k = 0; k < 16; k++) prog(1, 2, 'h100 + k);
    check("R9 no error at limit", prog_err, 0);
    prog(1, 2, 'h3C3);
    @(negedge clk);
    check("R9 error set", prog_err, 1);
    cmd(0, 1, 2); wait_idle();
    check("R9 data kept", last_ld[2], 'h10F);
    check("R8 count", wcount, 16);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule